// File: doc/BRIEF.md
# Battery-Well Power Status Register

This block is an 8-bit power-management register that sits in the always-on, battery-backed domain and runs on the slow real-time clock. It has its own battery-domain reset. Each field answers to a different set of clearing sources, so a main system reset leaves most of the register untouched. The register holds four things:

- a two-bit rate selector for a periodic software SMI timer;
- a sticky flag that records a battery-domain reset;
- a write-one-to-clear flag that records loss of the backup supply;
- a policy bit that chooses the sleep state to enter when main power comes back after a total loss.

A small resume path synchronises the resume-reset input into the real-time clock domain. When that input rises, the block raises a one-cycle go pulse. A decoder continuously presents the target state and says whether the wake sources are restricted. The SMI timer counts real-time clock ticks up to the selected limit. It then emits a one-cycle expiry pulse and starts again.

All pins are plain control and status. There is no streaming interface, so no back-pressure applies. A register write lands in a single cycle and is never refused.

Top module: `bwpr_top`

## Requirements
- R1: `rd_data` always shows the live register: bits 7:6 rate selector, bits 5:3 read as zero, bit 2 reset-status flag, bit 1 supply-failure flag, bit 0 after-loss policy.
- R2: The rate selector loads from `wr_data[7:6]` on a write. Both `bat_rst_n` low and `sys_rst_n` low clear it to 00.
- R3: While `bat_rst_n` is low, bit 2 reads 1. No other reset clears it. It changes only on a write, which loads `wr_data[2]`.
- R4: `supply_fail` high at a clock edge sets bit 1. A write with `wr_data[1]`=1 clears it. A write with `wr_data[1]`=0 leaves it alone. When a set and a clear arrive in the same cycle, the set wins.
- R5: `sys_rst_n` low leaves bits 2:0 unchanged.
- R6: Bit 0 loads from `wr_data[0]` on a write. It is cleared by `bat_rst_n` low, or by `cf9_wr` at a clock edge. `cf9_wr` wins over a write in the same cycle.
- R7: `resume_state` encodes S0 as 00, S4 as 01 and S5 as 10. It is 00 when bit 0 is 0. When bit 0 is 1, it is 01 if `prev_s4` is 1, and 10 otherwise.
- R8: `rsm_rst_n` is sampled on clock edges through two flops. A sampled rise makes `resume_go` high for exactly one cycle, starting two edges after the input rises. A low pulse that falls between two edges is not seen.
- R9: `smi_expire` pulses high for one cycle once every N clock cycles. N is 49, 524, 1049 or 2097 for rate codes 00, 01, 10 and 11. The counter restarts from zero on a system or battery-domain reset.
- R10: `wake_restrict` is 1 exactly when `resume_state` is S5. This limits wake sources to the power button plus the enables that survived the power loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Real-time clock of the battery domain |
| bat_rst_n | input | 1 | Battery-domain reset, asynchronous, active low |
| sys_rst_n | input | 1 | Main system reset, asynchronous, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| supply_fail | input | 1 | Backup-supply failure event |
| cf9_wr | input | 1 | Strobe for a write to the reset-control port |
| rsm_rst_n | input | 1 | Resume-reset input, asynchronous to `clk` |
| prev_s4 | input | 1 | The machine was in S4 before power was lost |
| resume_go | output | 1 | One-cycle pulse when resume reset releases |
| resume_state | output | 2 | Target state on power return |
| wake_restrict | output | 1 | Wake sources limited (target is S5) |
| smi_expire | output | 1 | One-cycle SMI timer expiry pulse |

## Verification
The results fall due at different times after a stimulus:

- Register fields and the timer count settle at the first clock edge after a write, an event or a strobe.
- The asynchronous resets act at once.
- The decoder outputs follow bit 0 and `prev_s4` within the same cycle.
- `resume_go` appears two edges after `rsm_rst_n` rises.

The bench keeps a behavioural reference that updates on the same edges and reacts at once to the resets. Inputs change on the falling clock edge. Every output is compared 2 ns after each falling edge, well clear of the rising edge where results change.

// File: rtl/bwpr_pkg.sv
package bwpr_pkg;
  localparam int REG_W  = 8;
  localparam int RATE_W = 2;
  typedef enum logic [1:0] {
    RES_S0 = 2'b00,
    RES_S4 = 2'b01,
    RES_S5 = 2'b10
  } resume_tgt_e;
endpackage

// File: rtl/bwpr_sync.sv
module bwpr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bwpr_resume.sv
module bwpr_resume
  import bwpr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rsm_rst_n,
  input  logic        policy,
  input  logic        prev_s4,
  output logic        go,
  output resume_tgt_e tgt,
  output logic        restrict_wake
);
  logic rsm_s;
  logic rsm_q;

  bwpr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (rsm_rst_n),
    .q    (rsm_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsm_q <= 1'b0;
    else        rsm_q <= rsm_s;
  end

  assign go = rsm_s & ~rsm_q;

  always_comb begin
    if (!policy)      tgt = RES_S0;
    else if (prev_s4) tgt = RES_S4;
    else              tgt = RES_S5;
  end

  assign restrict_wake = policy & ~prev_s4;

  assert_go_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !go);
endmodule

// File: rtl/bwpr_smi_timer.sv
module bwpr_smi_timer
  import bwpr_pkg::*;
#(
  parameter int LIM0 = 49,
  parameter int LIM1 = 524,
  parameter int LIM2 = 1049,
  parameter int LIM3 = 2097
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate,
  output logic              expire
);
  localparam int CW = $clog2(LIM3 + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  always_comb begin
    case (rate)
      2'd0:    lim = CW'(LIM0);
      2'd1:    lim = CW'(LIM1);
      2'd2:    lim = CW'(LIM2);
      default: lim = CW'(LIM3);
    endcase
  end

  assign expire = (cnt >= lim - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (expire) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  assert_expire_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);
  assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt == '0));
endmodule

// File: rtl/bwpr_top.sv
module bwpr_top
  import bwpr_pkg::*;
#(
  parameter int LIM0 = 49,
  parameter int LIM1 = 524,
  parameter int LIM2 = 1049,
  parameter int LIM3 = 2097
) (
  input  logic             clk,
  input  logic             bat_rst_n,
  input  logic             sys_rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             supply_fail,
  input  logic             cf9_wr,
  input  logic             rsm_rst_n,
  input  logic             prev_s4,
  output logic             resume_go,
  output logic [1:0]       resume_state,
  output logic             wake_restrict,
  output logic             smi_expire
);
  logic              core_rst_n;
  logic [RATE_W-1:0] rate;
  logic              rtc_sts;
  logic              pwr_flr;
  logic              ag3;
  resume_tgt_e       tgt;

  assign core_rst_n = bat_rst_n & sys_rst_n;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) rate <= '0;
    else if (wr_en)  rate <= wr_data[7:6];
  end

  always_ff @(posedge clk or negedge bat_rst_n) begin
    if (!bat_rst_n) rtc_sts <= 1'b1;
    else if (wr_en) rtc_sts <= wr_data[2];
  end

  always_ff @(posedge clk or negedge bat_rst_n) begin
    if (!bat_rst_n)                pwr_flr <= 1'b0;
    else if (supply_fail)          pwr_flr <= 1'b1;
    else if (wr_en && wr_data[1])  pwr_flr <= 1'b0;
  end

  always_ff @(posedge clk or negedge bat_rst_n) begin
    if (!bat_rst_n)  ag3 <= 1'b0;
    else if (cf9_wr) ag3 <= 1'b0;
    else if (wr_en)  ag3 <= wr_data[0];
  end

  assign rd_data = {rate, 3'b000, rtc_sts, pwr_flr, ag3};

  bwpr_resume #(.SYNC_STAGES(2)) u_resume (
    .clk          (clk),
    .rst_n        (bat_rst_n),
    .rsm_rst_n    (rsm_rst_n),
    .policy       (ag3),
    .prev_s4      (prev_s4),
    .go           (resume_go),
    .tgt          (tgt),
    .restrict_wake(wake_restrict)
  );

  assign resume_state = tgt;

  bwpr_smi_timer #(.LIM0(LIM0), .LIM1(LIM1), .LIM2(LIM2), .LIM3(LIM3)) u_timer (
    .clk   (clk),
    .rst_n (core_rst_n),
    .rate  (rate),
    .expire(smi_expire)
  );

  assert_flr_set_R4: assert property (@(posedge clk) disable iff (!bat_rst_n)
    supply_fail |=> pwr_flr);
  assert_sts_hold_R3: assert property (@(posedge clk) disable iff (!bat_rst_n)
    !wr_en |=> $stable(rtc_sts));
  assert_ag3_clear_R6: assert property (@(posedge clk) disable iff (!bat_rst_n)
    cf9_wr |=> !ag3);
  assert_wake_s5_R10: assert property (@(posedge clk) disable iff (!bat_rst_n)
    wake_restrict |-> (resume_state == RES_S5));
endmodule

// File: tb/bwpr_top_tb.sv
module bwpr_top_tb;
  logic       clk = 1'b0;
  logic       bat_rst_n = 1'b0;
  logic       sys_rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       supply_fail = 1'b0;
  logic       cf9_wr = 1'b0;
  logic       rsm_rst_n = 1'b0;
  logic       prev_s4 = 1'b0;
  logic       resume_go;
  logic [1:0] resume_state;
  logic       wake_restrict;
  logic       smi_expire;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bwpr_top u_dut (
    .clk(clk), .bat_rst_n(bat_rst_n), .sys_rst_n(sys_rst_n),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .supply_fail(supply_fail), .cf9_wr(cf9_wr), .rsm_rst_n(rsm_rst_n),
    .prev_s4(prev_s4), .resume_go(resume_go), .resume_state(resume_state),
    .wake_restrict(wake_restrict), .smi_expire(smi_expire)
  );

  // reference model
  int m_rate, m_sts, m_flr, m_ag3, m_cnt;
  int s1, s2, s2q;

  function automatic int lim_of(int r);
    case (r)
      0: return 49;
      1: return 524;
      2: return 1049;
      default: return 2097;
    endcase
  endfunction

  always @(posedge clk or negedge bat_rst_n) begin
    if (!bat_rst_n) begin
      m_sts = 1; m_flr = 0; m_ag3 = 0; s1 = 0; s2 = 0; s2q = 0;
    end else begin
      s2q = s2; s2 = s1; s1 = rsm_rst_n;
      if (wr_en) m_sts = wr_data[2];
      if (supply_fail) m_flr = 1;
      else if (wr_en && wr_data[1]) m_flr = 0;
      if (cf9_wr) m_ag3 = 0;
      else if (wr_en) m_ag3 = wr_data[0];
    end
  end

  always @(posedge clk or negedge bat_rst_n or negedge sys_rst_n) begin
    if (!bat_rst_n || !sys_rst_n) begin
      m_rate = 0; m_cnt = 0;
    end else begin
      if (m_cnt >= lim_of(m_rate) - 1) m_cnt = 0;
      else m_cnt = m_cnt + 1;
      if (wr_en) m_rate = wr_data[7:6];
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the rising edge
  always begin
    @(negedge clk);
    #2;
    if (!done) begin
      int exp_state;
      exp_state = (m_ag3 == 0) ? 0 : (prev_s4 ? 1 : 2);
      chk("R2 rate", rd_data[7:6], m_rate);
      chk("R1 reserved", rd_data[5:3], 0);
      chk("R3 rtc status", rd_data[2], m_sts);
      chk("R4 supply flag", rd_data[1], m_flr);
      chk("R6 policy", rd_data[0], m_ag3);
      chk("R8 resume go", resume_go, (s2 == 1 && s2q == 0) ? 1 : 0);
      chk("R7 resume state", resume_state, exp_state);
      chk("R10 wake restrict", wake_restrict, (exp_state == 2) ? 1 : 0);
      chk("R9 smi expire", smi_expire, (m_cnt >= lim_of(m_rate) - 1) ? 1 : 0);
    end
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    #2;
    chk("R3 reset value", rd_data, 8'h04);
    @(negedge clk); bat_rst_n = 1'b1;
    idle(2);
    @(negedge clk); sys_rst_n = 1'b1;
    idle(60);                           // R9 rate 00 period
    wr(8'hFF);                          // R2/R3/R6 load
    idle(2);
    @(negedge clk); supply_fail = 1'b1; // R4 set
    @(negedge clk); supply_fail = 1'b0;
    wr(8'hC1);                          // R4 write 0 no effect
    @(negedge clk); supply_fail = 1'b1; wr_en = 1'b1; wr_data = 8'hC3; // R4 set wins
    @(negedge clk); supply_fail = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    #2; chk("R4 set wins", rd_data[1], 1);
    wr(8'h07);                          // R4 clear, rate 00, sts 1, ag3 1
    prev_s4 = 1'b1; idle(2);            // R7 S4
    prev_s4 = 1'b0; idle(2);            // R7/R10 S5
    wr(8'h45);
    @(negedge clk); sys_rst_n = 1'b0;   // R5
    @(negedge clk); #2;
    chk("R5 bits kept", rd_data[2:0], 3'b101);
    chk("R2 sys clears rate", rd_data[7:6], 0);
    @(negedge clk); sys_rst_n = 1'b1;
    @(negedge clk); cf9_wr = 1'b1; wr_en = 1'b1; wr_data = 8'h01; // R6 cf9 wins
    @(negedge clk); cf9_wr = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    #2; chk("R6 cf9 clears", rd_data[0], 0);
    wr(8'h01);
    @(negedge clk); rsm_rst_n = 1'b1;   // R8 rise
    idle(5);
    @(negedge clk); rsm_rst_n = 1'b0;
    idle(4);
    @(negedge clk); #3 rsm_rst_n = 1'b1; #4 rsm_rst_n = 1'b0; // R8 short pulse missed
    idle(4);
    @(negedge clk); rsm_rst_n = 1'b1;
    idle(4);
    wr(8'h40);                          // R9 rate 01
    idle(1100);
    wr(8'hC0);                          // R9 rate 11
    idle(2200);
    wr(8'h80);                          // R9 rate 10
    idle(300);
    @(negedge clk); bat_rst_n = 1'b0;   // R3 battery reset
    @(negedge clk); #2;
    chk("R3 battery reset sets", rd_data, 8'h04);
    @(negedge clk); bat_rst_n = 1'b1;
    idle(10);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule